// File: doc/BRIEF.md
# Cache Block Zeroing Engine

This engine carries out the "zero a cache block" operation of a processor core. A request brings a byte address, a block-size exponent and a translation-fault flag. The block is 2^exponent bytes, with the exponent limited to 12 (4096 bytes); 6, giving 64-byte blocks, is the usual platform setting. The engine clears the address bits below the block size, so any address inside a block selects the whole block. It then writes zero words over the block through a word-wide write port with a valid/ready handshake and a separate response channel.

Writes go out one at a time in ascending address order. Each write waits for its response before the next is issued. When the block is smaller than a bus word, one write is issued whose byte strobes cover only the block. A translation fault flagged with the request ends the operation at once, with no write. An error response aborts the walk. In both cases the engine reports a fault against the original request address. A one-cycle done pulse with a fault flag closes every accepted request. Enable and privilege checks are made upstream.

Top module: `blkz_engine`

## Requirements
- R1: After reset `busy`, `done` and `wr_valid` are low.
- R2: A request is accepted only on a cycle where `req_valid` is high and `busy` is low. A request presented while `busy` is high is ignored: it produces no write and no done pulse.
- R3: The block start is `req_addr` with its low `min(req_exp,12)` bits cleared. Every write address is word aligned (low 2 bits zero), and writes proceed upward in steps of 4 bytes from the word holding the block start.
- R4: Every write carries `wr_data` equal to zero. For an exponent of 2 or more, exactly 2^(e-2) writes are issued, each with `wr_strb` = 4'b1111.
- R5: For an exponent of 0 or 1, exactly one write is issued. Strobe bit i enables byte lane i, which is the byte at word address + i. The strobe covers the 2^e lanes starting at lane (`req_addr[1:0]` with its low e bits cleared).
- R6: An exponent of 13, 14 or 15 behaves exactly as 12.
- R7: A request accepted with `req_xlat_fault` high issues no write. The cycle after acceptance it gives `done` with `done_fault` high and `fault_addr` equal to the unaligned request address.
- R8: A write response with `rsp_err` high aborts the operation. No further write is issued, and the next cycle gives `done` with `done_fault` high and `fault_addr` equal to the request address.
- R9: `done` is a one-cycle pulse with `busy` low. On success it comes, with `done_fault` low, the cycle after the response to the last write of the block, and never earlier.
- R10: While `wr_valid` is high and `wr_ready` is low, `wr_valid`, `wr_addr` and `wr_strb` hold their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request present |
| req_addr | input | AW | Request byte address |
| req_exp | input | EW | Block-size exponent |
| req_xlat_fault | input | 1 | Translation failed for this request |
| busy | output | 1 | Engine is walking a block; requests are not taken |
| done | output | 1 | One-cycle completion pulse |
| done_fault | output | 1 | Completion was a fault (valid with done) |
| fault_addr | output | AW | Request address of a faulting operation |
| wr_valid | output | 1 | Write request valid |
| wr_ready | input | 1 | Memory accepts the write |
| wr_addr | output | AW | Word-aligned write address |
| wr_data | output | DW | Write data (zero) |
| wr_strb | output | DW/8 | Byte-lane enables |
| rsp_valid | input | 1 | Write response present |
| rsp_err | input | 1 | Write response reports an error |

## Verification
Completion and acceptance can fall in the same cycle. The done pulse leaves the engine idle, so a request already held high is taken in that very cycle. The bench holds `req_valid` high across the end of a one-word operation and again across two back-to-back translation-fault requests. It judges the case by counting done pulses and writes, and by seeing `busy` high on the cycle right after the first pulse. The sweep over every exponent and several offsets, with error injection at the first, a middle and the last word, covers the remaining functions.

// File: rtl/blkz_pkg.sv
package blkz_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_ISSUE = 2'd1,
    ST_WAIT  = 2'd2
  } blkz_state_t;
endpackage

// File: rtl/blkz_align.sv
module blkz_align #(
  parameter int AW      = 32,
  parameter int DW      = 32,
  parameter int EW      = 4,
  parameter int MAX_EXP = 12,
  localparam int SW     = DW / 8,
  localparam int LB     = (SW > 1) ? $clog2(SW) : 1,
  localparam int CW     = MAX_EXP + 1
) (
  input  logic [AW-1:0] addr,
  input  logic [EW-1:0] exp_raw,
  output logic [AW-1:0] word_base,
  output logic [CW-1:0] last_idx,
  output logic [SW-1:0] strb
);
  logic [EW-1:0] exp_c;
  logic [AW-1:0] low_mask;
  logic [AW-1:0] blk_base;

  // limit exponent, then clear the bits below the block size
  always_comb begin
    exp_c    = (exp_raw > EW'(MAX_EXP)) ? EW'(MAX_EXP) : exp_raw;
    low_mask = (AW'(1) << exp_c) - AW'(1);
    blk_base = addr & ~low_mask;
  end

  generate
    if (SW > 1) begin : g_wide
      logic [31:0] lanes;
      always_comb begin
        word_base = {blk_base[AW-1:LB], {LB{1'b0}}};
        lanes     = 32'd1 << exp_c;
        if (exp_c >= EW'(LB)) begin
          last_idx = CW'((32'd1 << (exp_c - EW'(LB))) - 32'd1);
          strb     = '1;
        end else begin
          last_idx = '0;
          strb     = SW'(((32'd1 << lanes) - 32'd1) << blk_base[LB-1:0]);
        end
      end
    end else begin : g_byte
      always_comb begin
        word_base = blk_base;
        last_idx  = CW'((32'd1 << exp_c) - 32'd1);
        strb      = '1;
      end
    end
  endgenerate
endmodule

// File: rtl/blkz_walker.sv
module blkz_walker
  import blkz_pkg::*;
#(
  parameter int AW      = 32,
  parameter int DW      = 32,
  parameter int MAX_EXP = 12,
  localparam int SW     = DW / 8,
  localparam int CW     = MAX_EXP + 1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          start,
  input  logic          start_fault,
  input  logic [AW-1:0] start_addr,
  input  logic [AW-1:0] start_base,
  input  logic [CW-1:0] start_last,
  input  logic [SW-1:0] start_strb,
  input  logic          wr_ready,
  input  logic          rsp_valid,
  input  logic          rsp_err,
  output logic          wr_valid,
  output logic [AW-1:0] wr_addr,
  output logic [SW-1:0] wr_strb,
  output logic          busy,
  output logic          done,
  output logic          done_fault,
  output logic [AW-1:0] fault_addr
);
  blkz_state_t   state;
  logic [CW-1:0] left;
  logic [AW-1:0] orig_addr;

  always_ff @(posedge clk) begin
    if (rst) begin
      state      <= ST_IDLE;
      wr_valid   <= 1'b0;
      wr_addr    <= '0;
      wr_strb    <= '0;
      busy       <= 1'b0;
      done       <= 1'b0;
      done_fault <= 1'b0;
      fault_addr <= '0;
      left       <= '0;
      orig_addr  <= '0;
    end else begin
      done <= 1'b0;
      case (state)
        ST_IDLE: begin
          if (start) begin
            orig_addr <= start_addr;
            if (start_fault) begin
              done       <= 1'b1;
              done_fault <= 1'b1;
              fault_addr <= start_addr;
            end else begin
              state    <= ST_ISSUE;
              busy     <= 1'b1;
              wr_valid <= 1'b1;
              wr_addr  <= start_base;
              wr_strb  <= start_strb;
              left     <= start_last;
            end
          end
        end
        ST_ISSUE: begin
          if (wr_ready) begin
            wr_valid <= 1'b0;
            state    <= ST_WAIT;
          end
        end
        ST_WAIT: begin
          if (rsp_valid) begin
            if (rsp_err) begin
              state      <= ST_IDLE;
              busy       <= 1'b0;
              done       <= 1'b1;
              done_fault <= 1'b1;
              fault_addr <= orig_addr;
            end else if (left == '0) begin
              state      <= ST_IDLE;
              busy       <= 1'b0;
              done       <= 1'b1;
              done_fault <= 1'b0;
            end else begin
              left     <= left - CW'(1);
              wr_addr  <= wr_addr + AW'(SW);
              wr_valid <= 1'b1;
              state    <= ST_ISSUE;
            end
          end
        end
        default: begin
          state    <= ST_IDLE;
          busy     <= 1'b0;
          wr_valid <= 1'b0;
        end
      endcase
    end
  end
endmodule

// File: rtl/blkz_engine.sv
module blkz_engine #(
  parameter int AW      = 32,
  parameter int DW      = 32,
  parameter int EW      = 4,
  parameter int MAX_EXP = 12
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            req_valid,
  input  logic [AW-1:0]   req_addr,
  input  logic [EW-1:0]   req_exp,
  input  logic            req_xlat_fault,
  output logic            busy,
  output logic            done,
  output logic            done_fault,
  output logic [AW-1:0]   fault_addr,
  output logic            wr_valid,
  input  logic            wr_ready,
  output logic [AW-1:0]   wr_addr,
  output logic [DW-1:0]   wr_data,
  output logic [DW/8-1:0] wr_strb,
  input  logic            rsp_valid,
  input  logic            rsp_err
);
  localparam int SW = DW / 8;
  localparam int CW = MAX_EXP + 1;

  logic          accept;
  logic [AW-1:0] a_base;
  logic [CW-1:0] a_last;
  logic [SW-1:0] a_strb;

  assign accept  = req_valid & ~busy;
  assign wr_data = '0;

  blkz_align #(.AW(AW), .DW(DW), .EW(EW), .MAX_EXP(MAX_EXP)) u_align (
    .addr      (req_addr),
    .exp_raw   (req_exp),
    .word_base (a_base),
    .last_idx  (a_last),
    .strb      (a_strb)
  );

  blkz_walker #(.AW(AW), .DW(DW), .MAX_EXP(MAX_EXP)) u_walk (
    .clk         (clk),
    .rst         (rst),
    .start       (accept),
    .start_fault (req_xlat_fault),
    .start_addr  (req_addr),
    .start_base  (a_base),
    .start_last  (a_last),
    .start_strb  (a_strb),
    .wr_ready    (wr_ready),
    .rsp_valid   (rsp_valid),
    .rsp_err     (rsp_err),
    .wr_valid    (wr_valid),
    .wr_addr     (wr_addr),
    .wr_strb     (wr_strb),
    .busy        (busy),
    .done        (done),
    .done_fault  (done_fault),
    .fault_addr  (fault_addr)
  );
endmodule

// File: rtl/blkz_engine_chk.sv
module blkz_engine_chk #(
  parameter int AW = 32,
  parameter int DW = 32
) (
  input logic            clk,
  input logic            rst,
  input logic            busy,
  input logic            done,
  input logic            done_fault,
  input logic            wr_valid,
  input logic            wr_ready,
  input logic [AW-1:0]   wr_addr,
  input logic [DW/8-1:0] wr_strb,
  input logic            rsp_valid,
  input logic            rsp_err
);
  // R10: request held until taken
  p_hold_r10: assert property (@(posedge clk) disable iff (rst)
    (wr_valid && !wr_ready) |=> (wr_valid && $stable(wr_addr) && $stable(wr_strb)));

  // R2: no write outside a busy period
  p_idle_quiet_r2: assert property (@(posedge clk) disable iff (rst)
    !busy |-> !wr_valid);

  // R3: word-aligned write addresses
  p_aligned_r3: assert property (@(posedge clk) disable iff (rst)
    wr_valid |-> (wr_addr[1:0] == 2'b00));

  // R5: a write always enables at least one lane
  p_strb_live_r5: assert property (@(posedge clk) disable iff (rst)
    wr_valid |-> (wr_strb != '0));

  // R8: an error response ends the walk with a fault
  p_err_abort_r8: assert property (@(posedge clk) disable iff (rst)
    (busy && !wr_valid && rsp_valid && rsp_err) |=> (done && done_fault && !busy && !wr_valid));

  // R9: leaving busy always comes with completion; done only when idle
  p_fell_done_r9: assert property (@(posedge clk) disable iff (rst)
    $fell(busy) |-> done);
  p_done_idle_r9: assert property (@(posedge clk) disable iff (rst)
    done |-> (!busy && !wr_valid));
endmodule

bind blkz_engine blkz_engine_chk #(.AW(AW), .DW(DW)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .busy      (busy),
  .done      (done),
  .done_fault(done_fault),
  .wr_valid  (wr_valid),
  .wr_ready  (wr_ready),
  .wr_addr   (wr_addr),
  .wr_strb   (wr_strb),
  .rsp_valid (rsp_valid),
  .rsp_err   (rsp_err)
);

// File: tb/sim_blkz_engine.sv
`timescale 1ns/1ps
module sim_blkz_engine;
  localparam int AW = 32;
  localparam int DW = 32;
  localparam int EW = 4;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          req_valid = 1'b0;
  logic [AW-1:0] req_addr = '0;
  logic [EW-1:0] req_exp = '0;
  logic          req_xlat_fault = 1'b0;
  logic          busy, done, done_fault, wr_valid;
  logic [AW-1:0] fault_addr, wr_addr;
  logic [DW-1:0] wr_data;
  logic [3:0]    wr_strb;
  logic          wr_ready = 1'b0;
  logic          rsp_valid = 1'b0;
  logic          rsp_err = 1'b0;

  int total = 0;
  int bad = 0;

  // slave / monitor state
  logic [AW-1:0] log_addr [0:1100];
  logic [3:0]    log_strb [0:1100];
  int  log_n = 0;
  int  err_at = -1;
  int  nz_data = 0;
  int  done_cnt = 0;
  logic last_fault = 1'b0;
  logic [AW-1:0] last_faddr = '0;
  logic [1:0] rdy_ctr = '0;

  always #4 clk = ~clk;

  blkz_engine #(.AW(AW), .DW(DW), .EW(EW), .MAX_EXP(12)) u0 (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_addr(req_addr),
    .req_exp(req_exp), .req_xlat_fault(req_xlat_fault), .busy(busy),
    .done(done), .done_fault(done_fault), .fault_addr(fault_addr),
    .wr_valid(wr_valid), .wr_ready(wr_ready), .wr_addr(wr_addr),
    .wr_data(wr_data), .wr_strb(wr_strb), .rsp_valid(rsp_valid),
    .rsp_err(rsp_err)
  );

  always @(posedge clk) begin
    rdy_ctr   <= rdy_ctr + 2'd1;
    wr_ready  <= (rdy_ctr != 2'd3);
    rsp_valid <= 1'b0;
    rsp_err   <= 1'b0;
    if (!rst && wr_valid && wr_ready) begin
      if (log_n <= 1100) begin
        log_addr[log_n] <= wr_addr;
        log_strb[log_n] <= wr_strb;
      end
      if (wr_data != '0) nz_data <= nz_data + 1;
      rsp_valid <= 1'b1;
      rsp_err   <= (log_n == err_at);
      log_n     <= log_n + 1;
    end
    if (!rst && done) begin
      done_cnt   <= done_cnt + 1;
      last_fault <= done_fault;
      last_faddr <= fault_addr;
    end
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic pulse_req(input logic [AW-1:0] a, input int e, input bit xf);
    @(negedge clk);
    req_addr = a; req_exp = EW'(e); req_xlat_fault = xf; req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  task automatic wait_done(input int target);
    int guard = 0;
    while (done_cnt < target && guard < 20000) begin
      @(negedge clk);
      guard++;
    end
    chk(done_cnt >= target, "R9", "done pulse timeout", done_cnt, target);
  endtask

  task automatic run_op(input logic [AW-1:0] a, input int e, input bit xf,
                        input int inj, input string tag);
    int ec, nw, lanes, base0, off;
    logic [AW-1:0] blk, wb;
    logic [3:0] es;
    int exp_n, bad_words;
    @(negedge clk);
    log_n = 0; err_at = inj; done_cnt = 0;
    pulse_req(a, e, xf);
    wait_done(1);
    repeat (2) @(negedge clk);
    ec  = (e > 12) ? 12 : e;
    blk = a & ~((AW'(1) << ec) - AW'(1));
    wb  = blk & ~AW'(3);
    nw  = (ec >= 2) ? (1 << (ec - 2)) : 1;
    if (ec >= 2) es = 4'b1111;
    else begin
      lanes = 1 << ec;
      off = int'(blk[1:0]);
      es = 4'(((1 << lanes) - 1) << off);
    end
    exp_n = xf ? 0 : ((inj >= 0 && inj < nw) ? inj + 1 : nw);
    chk(log_n == exp_n, tag, "write count", log_n, exp_n);
    chk(done_cnt == 1, "R9", "one done per request", done_cnt, 1);
    if (xf || (inj >= 0 && inj < nw)) begin
      chk(last_fault == 1'b1, xf ? "R7" : "R8", "fault flag", last_fault, 1);
      chk(last_faddr == a, xf ? "R7" : "R8", "fault address", last_faddr, a);
    end else begin
      chk(last_fault == 1'b0, "R9", "success flag", last_fault, 0);
    end
    bad_words = 0;
    for (int i = 0; i < log_n && i <= 1100; i++) begin
      if (log_addr[i] != wb + AW'(4 * i) || log_strb[i] != es) begin
        if (bad_words == 0)
          chk(0, tag, $sformatf("word %0d addr/strb", i),
              {log_addr[i], 28'(log_strb[i])}, {wb + AW'(4 * i), 28'(es)});
        bad_words++;
      end
    end
    if (bad_words == 0 && log_n > 0)
      chk(1, tag, "word sequence", 0, 0);
  endtask

  initial begin
    logic [AW-1:0] addrs [0:2];
    int dbase;
    addrs[0] = 32'h8000_1237;
    addrs[1] = 32'h0004_5FFD;
    addrs[2] = 32'h1234_0A02;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    chk(busy == 1'b0, "R1", "busy after reset", busy, 0);
    chk(done == 1'b0, "R1", "done after reset", done, 0);
    chk(wr_valid == 1'b0, "R1", "wr_valid after reset", wr_valid, 0);

    // R3 R4 R5 R6 sweep over every exponent and several offsets
    for (int e = 0; e < 16; e++) begin
      for (int k = 0; k < 3; k++) begin
        if (e < 2) run_op(addrs[k], e, 1'b0, -1, "R5");
        else if (e > 12) run_op(addrs[k], e, 1'b0, -1, "R6");
        else run_op(addrs[k], e, 1'b0, -1, "R3");
      end
    end
    for (int o = 0; o < 4; o++) begin
      run_op(32'h0000_0100 + AW'(o), 0, 1'b0, -1, "R5");
      run_op(32'h0000_0100 + AW'(o), 1, 1'b0, -1, "R5");
    end
    chk(nz_data == 0, "R4", "nonzero write data seen", nz_data, 0);

    // R7 translation fault
    run_op(32'h0000_7777, 6, 1'b1, -1, "R7");
    // R8 error at first, middle and last word
    run_op(32'h0000_2345, 4, 1'b0, 0, "R8");
    run_op(32'h0000_2345, 4, 1'b0, 2, "R8");
    run_op(32'h0000_2345, 4, 1'b0, 3, "R8");

    // R2 request while busy is ignored
    @(negedge clk);
    log_n = 0; err_at = -1; done_cnt = 0;
    pulse_req(32'h0000_4000, 5, 1'b0);
    repeat (3) @(negedge clk);
    chk(busy == 1'b1, "R2", "busy during walk", busy, 1);
    pulse_req(32'h0000_9000, 2, 1'b1);
    wait_done(1);
    repeat (10) @(negedge clk);
    chk(done_cnt == 1, "R2", "ignored request made a done", done_cnt, 1);
    chk(log_n == 8, "R2", "write count with ignored request", log_n, 8);
    chk(last_fault == 1'b0, "R2", "ignored fault leaked", last_fault, 0);

    // acceptance in the same cycle as done: held request, one-word block
    log_n = 0; err_at = -1; done_cnt = 0;
    req_addr = 32'h0000_5004; req_exp = 4'd2; req_xlat_fault = 1'b0;
    req_valid = 1'b1;
    wait_done(1);
    chk(busy == 1'b1, "R2", "request taken in done cycle", busy, 1);
    req_valid = 1'b0;
    wait_done(2);
    repeat (2) @(negedge clk);
    chk(done_cnt == 2, "R9", "back-to-back done count", done_cnt, 2);
    chk(log_n == 2, "R4", "back-to-back write count", log_n, 2);

    // two translation faults back to back: one done each cycle
    dbase = 0; done_cnt = 0; log_n = 0;
    @(negedge clk);
    req_addr = 32'h0000_6001; req_exp = 4'd6; req_xlat_fault = 1'b1;
    req_valid = 1'b1;
    @(negedge clk);
    req_addr = 32'h0000_6ABC;
    @(negedge clk);
    req_valid = 1'b0; req_xlat_fault = 1'b0;
    repeat (3) @(negedge clk);
    chk(done_cnt == dbase + 2, "R7", "fault done count", done_cnt, dbase + 2);
    chk(last_faddr == 32'h0000_6ABC, "R7", "second fault address", last_faddr, 32'h0000_6ABC);
    chk(log_n == 0, "R7", "writes on fault", log_n, 0);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    total++;
    bad++;
    $display("FAIL watchdog expired actual=1 expected=0");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule